// File: doc/BRIEF.md
# Fixed-Field Instruction Decoder

This block turns one 16-bit instruction word into the control and index signals an execute stage needs. The word is four 4-bit fields: the opcode in bits [15:12], then three register fields called r2 ([11:8]), r1 ([7:4]) and r0 ([3:0]). Most instructions use the three fields as register numbers. A few give them another meaning: r1 and r0 together form a byte immediate, r0 alone becomes a signed offset counted in 32-bit words, or r2 becomes a branch condition code.

The decoder is purely combinational. It reports the destination register and its write enable, the two source register numbers, the register that supplies store data, the write-back source, the memory access kind, stack pointer stepping, an immediate, the branch condition and the total instruction length in bytes. The fetch stage uses the length (2, 4 or 6) to know how many extra bytes follow the opcode word. Registers below `NUM_CONST` hold fixed values (0 and 1 by default). The decoder drops any write enable aimed at them, so an instruction that targets them does no harm.

Top module: `instr_decoder`

## Requirements
- R1: Opcodes are numbered 0 move, 1 pop, 2 push, 3 alu, 4 mover, 5 stor, 6 storl, 7 load, 8 loadl, 9 loadi, 10 loadil, 11 jal, 12 halt, 13 setb, and `op_o` repeats bits [15:12]. For move (0), the destination is r2, source A is r1, source B is r0, the write-back select is 0 (sum) and the write enable is set.
- R2: `len_o` is 6 for opcode 10, 4 for opcode 13 and 2 for every other opcode.
- R3: loadi (9) writes r2 with write-back select 3 (immediate) and sets the low-byte-only flag. The immediate is {r1,r0} zero-extended to XLEN.
- R4: mover (4) writes r2 with write-back select 0. Source A is r1 and source B is register 0. The immediate is 4 times r0, where r0 is read as a signed value from -8 to 7 and sign-extended to XLEN.
- R5: Memory opcodes address through source A = r1 and source B = r0. Opcodes 7 and 8 set `mem_rd_o`, write r2 with write-back select 2 (memory), and only 7 sets `mem_byte_o` and the low-byte-only flag. Opcodes 5 and 6 set `mem_wr_o` with store data from r2, and only 5 sets `mem_byte_o`.
- R6: pop (1) and push (2) use source A = 14 and source B = 0 and set `sp_we_o`. `sp_delta_o` is +4 for pop and -4 (two's complement) for push. Pop is a 32-bit read into r2 with write-back select 2. Push is a 32-bit write of r2.
- R7: jal (11) writes r2 with write-back select 5 (program counter), sets `pc_we_o`, and presents r1 and r0 as sources A and B.
- R8: setb (13) drives `cond_o` with r2, sets `branch_o`, and writes r1 with write-back select 6 (condition flag).
- R9: With protection enabled, `dst_we_o` is 0 whenever the destination index is below `NUM_CONST` (registers 0 and 1 by default). All other outputs are unchanged.
- R10: halt (12) sets `halt_o`. No register, memory, stack pointer or program counter write enable is raised.
- R11: Opcodes 14 and 15 raise no enable or flag, and every index, immediate and select is 0.
- R12: alu (3) writes r2 from sources r1 and r0 with write-back select 1 and sets `alu_o`. No other opcode sets `alu_o`.
- R13: loadil (10) writes all of r2 with write-back select 4 (long immediate from the following bytes). It reads no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| op_o | output | 4 | Opcode field |
| dst_idx_o | output | 4 | Destination register number |
| src_a_idx_o | output | 4 | First source register number |
| src_b_idx_o | output | 4 | Second source register number |
| data_idx_o | output | 4 | Store data register number |
| dst_we_o | output | 1 | Destination write enable after protection |
| byte_wr_o | output | 1 | Write only bits [7:0] of the destination |
| wb_sel_o | output | 3 | Write-back source select |
| sp_we_o | output | 1 | Stack pointer update |
| sp_delta_o | output | XLEN | Signed stack pointer step |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_byte_o | output | 1 | Access is one byte (else 32-bit) |
| imm_o | output | XLEN | Immediate value |
| cond_o | output | 4 | Branch condition code |
| branch_o | output | 1 | Conditional set-and-branch |
| pc_we_o | output | 1 | Unconditional program counter load |
| alu_o | output | 1 | ALU operation selected |
| halt_o | output | 1 | Stop execution |
| len_o | output | 3 | Instruction length in bytes |

## Verification
Every output is a combinational function of `instr_i`, so each result is due in the same cycle the word is applied, with no register anywhere on the path. The bench applies each of the 65536 words just after a rising edge. It samples at the following falling edge, half a period later, when the outputs have long settled and before the next word arrives. At that point it compares the whole output set and the length against values it computes from the field rules.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

   typedef enum logic [3:0] {
      OP_MOVE   = 4'd0,
      OP_POP    = 4'd1,
      OP_PUSH   = 4'd2,
      OP_ALU    = 4'd3,
      OP_MOVER  = 4'd4,
      OP_STOR   = 4'd5,
      OP_STORL  = 4'd6,
      OP_LOAD   = 4'd7,
      OP_LOADL  = 4'd8,
      OP_LOADI  = 4'd9,
      OP_LOADIL = 4'd10,
      OP_JAL    = 4'd11,
      OP_HALT   = 4'd12,
      OP_SETB   = 4'd13,
      OP_RSV14  = 4'd14,
      OP_RSV15  = 4'd15
   } opcode_e;

   typedef enum logic [2:0] {
      WB_SUM  = 3'd0,
      WB_ALU  = 3'd1,
      WB_MEM  = 3'd2,
      WB_IMM  = 3'd3,
      WB_EXT  = 3'd4,
      WB_PC   = 3'd5,
      WB_FLAG = 3'd6
   } wb_sel_e;

   typedef enum logic [1:0] {DST_NONE, DST_R2, DST_R1} dst_sel_e;
   typedef enum logic [1:0] {SRC_NONE, SRC_R1, SRC_SP} srca_sel_e;
   typedef enum logic [1:0] {IMM_NONE, IMM_BYTE, IMM_WOFF} imm_sel_e;

   typedef struct packed {
      logic [3:0] op;
      logic [3:0] r2;
      logic [3:0] r1;
      logic [3:0] r0;
   } ifields_t;

   typedef struct packed {
      dst_sel_e  dst;
      srca_sel_e src_a;
      logic      src_b_r0;
      logic      data_r2;
      logic      we;
      logic      byte_wr;
      wb_sel_e   wb;
      logic      mem_rd;
      logic      mem_wr;
      logic      mem_byte;
      logic      sp_up;
      logic      sp_dn;
      imm_sel_e  imm;
      logic      cond_r2;
      logic      branch;
      logic      pc_we;
      logic      alu;
      logic      halt;
      logic [2:0] len;
   } ctrl_t;

endpackage

// File: rtl/instr_dec_ctrl.sv
module instr_dec_ctrl
   import instr_dec_pkg::*;
(
   input  logic [3:0] op_i,
   output ctrl_t      ctrl_o
);

   always_comb begin
      ctrl_o          = '0;
      ctrl_o.dst      = DST_NONE;
      ctrl_o.src_a    = SRC_NONE;
      ctrl_o.wb       = WB_SUM;
      ctrl_o.imm      = IMM_NONE;
      ctrl_o.len      = 3'd2;
      case (opcode_e'(op_i))
         OP_MOVE: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1;
            ctrl_o.src_a = SRC_R1; ctrl_o.src_b_r0 = 1'b1;
         end
         OP_POP: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1; ctrl_o.wb = WB_MEM;
            ctrl_o.src_a = SRC_SP; ctrl_o.mem_rd = 1'b1; ctrl_o.sp_up = 1'b1;
         end
         OP_PUSH: begin
            ctrl_o.src_a = SRC_SP; ctrl_o.data_r2 = 1'b1;
            ctrl_o.mem_wr = 1'b1; ctrl_o.sp_dn = 1'b1;
         end
         OP_ALU: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1; ctrl_o.wb = WB_ALU;
            ctrl_o.src_a = SRC_R1; ctrl_o.src_b_r0 = 1'b1; ctrl_o.alu = 1'b1;
         end
         OP_MOVER: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1;
            ctrl_o.src_a = SRC_R1; ctrl_o.imm = IMM_WOFF;
         end
         OP_STOR, OP_STORL: begin
            ctrl_o.src_a = SRC_R1; ctrl_o.src_b_r0 = 1'b1;
            ctrl_o.data_r2 = 1'b1; ctrl_o.mem_wr = 1'b1;
            ctrl_o.mem_byte = (op_i == OP_STOR);
         end
         OP_LOAD, OP_LOADL: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1; ctrl_o.wb = WB_MEM;
            ctrl_o.src_a = SRC_R1; ctrl_o.src_b_r0 = 1'b1; ctrl_o.mem_rd = 1'b1;
            ctrl_o.mem_byte = (op_i == OP_LOAD);
            ctrl_o.byte_wr  = (op_i == OP_LOAD);
         end
         OP_LOADI: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1; ctrl_o.wb = WB_IMM;
            ctrl_o.byte_wr = 1'b1; ctrl_o.imm = IMM_BYTE;
         end
         OP_LOADIL: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1; ctrl_o.wb = WB_EXT;
            ctrl_o.len = 3'd6;
         end
         OP_JAL: begin
            ctrl_o.dst = DST_R2; ctrl_o.we = 1'b1; ctrl_o.wb = WB_PC;
            ctrl_o.src_a = SRC_R1; ctrl_o.src_b_r0 = 1'b1; ctrl_o.pc_we = 1'b1;
         end
         OP_HALT: ctrl_o.halt = 1'b1;
         OP_SETB: begin
            ctrl_o.dst = DST_R1; ctrl_o.we = 1'b1; ctrl_o.wb = WB_FLAG;
            ctrl_o.cond_r2 = 1'b1; ctrl_o.branch = 1'b1; ctrl_o.len = 3'd4;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/instr_dec_fields.sv
module instr_dec_fields
   import instr_dec_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int SP_IDX  = 14,
   parameter int WORD_SH = 2
) (
   input  logic [15:0]     instr_i,
   input  ctrl_t           ctrl_i,
   output logic [3:0]      dst_idx_o,
   output logic [3:0]      src_a_idx_o,
   output logic [3:0]      src_b_idx_o,
   output logic [3:0]      data_idx_o,
   output logic [XLEN-1:0] imm_o,
   output logic [3:0]      cond_o
);

   localparam logic [3:0] SP_NUM = 4'(SP_IDX);

   ifields_t f;
   logic [XLEN-1:0] byte_zx;
   logic [XLEN-1:0] off_sx;

   assign f       = ifields_t'(instr_i);
   assign byte_zx = {{(XLEN-8){1'b0}}, f.r1, f.r0};
   assign off_sx  = {{(XLEN-4){f.r0[3]}}, f.r0} << WORD_SH;

   always_comb begin
      case (ctrl_i.dst)
         DST_R2:  dst_idx_o = f.r2;
         DST_R1:  dst_idx_o = f.r1;
         default: dst_idx_o = '0;
      endcase
      case (ctrl_i.src_a)
         SRC_R1:  src_a_idx_o = f.r1;
         SRC_SP:  src_a_idx_o = SP_NUM;
         default: src_a_idx_o = '0;
      endcase
      case (ctrl_i.imm)
         IMM_BYTE: imm_o = byte_zx;
         IMM_WOFF: imm_o = off_sx;
         default:  imm_o = '0;
      endcase
   end

   assign src_b_idx_o = ctrl_i.src_b_r0 ? f.r0 : '0;
   assign data_idx_o  = ctrl_i.data_r2  ? f.r2 : '0;
   assign cond_o      = ctrl_i.cond_r2  ? f.r2 : '0;

endmodule

// File: rtl/instr_dec_guard.sv
module instr_dec_guard #(
   parameter int NUM_CONST = 2,
   parameter bit PROTECT   = 1'b1
) (
   input  logic [3:0] dst_idx_i,
   input  logic       we_raw_i,
   output logic       we_o
);

   localparam logic [3:0] FIRST_RW = 4'(NUM_CONST);

   generate
      if (PROTECT && NUM_CONST > 0) begin : g_masked
         assign we_o = we_raw_i && (dst_idx_i >= FIRST_RW);
      end else begin : g_open
         assign we_o = we_raw_i;
      end
   endgenerate

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
   import instr_dec_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NUM_CONST = 2,
   parameter bit PROTECT   = 1'b1,
   parameter int SP_IDX    = 14,
   parameter int SP_STEP   = 4
) (
   input  logic [15:0]     instr_i,
   output logic [3:0]      op_o,
   output logic [3:0]      dst_idx_o,
   output logic [3:0]      src_a_idx_o,
   output logic [3:0]      src_b_idx_o,
   output logic [3:0]      data_idx_o,
   output logic            dst_we_o,
   output logic            byte_wr_o,
   output logic [2:0]      wb_sel_o,
   output logic            sp_we_o,
   output logic [XLEN-1:0] sp_delta_o,
   output logic            mem_rd_o,
   output logic            mem_wr_o,
   output logic            mem_byte_o,
   output logic [XLEN-1:0] imm_o,
   output logic [3:0]      cond_o,
   output logic            branch_o,
   output logic            pc_we_o,
   output logic            alu_o,
   output logic            halt_o,
   output logic [2:0]      len_o
);

   localparam logic [XLEN-1:0] STEP     = XLEN'(SP_STEP);
   localparam int              WORD_SH  = $clog2(SP_STEP);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("instr_decoder: XLEN must hold a byte immediate");
      end
      if (SP_IDX < NUM_CONST || SP_IDX > 15) begin : g_bad_sp
         $error("instr_decoder: stack pointer must be a writable register");
      end
      if (NUM_CONST < 0 || NUM_CONST > 15) begin : g_bad_const
         $error("instr_decoder: NUM_CONST out of range");
      end
      if ((1 << WORD_SH) != SP_STEP) begin : g_bad_step
         $error("instr_decoder: SP_STEP must be a power of two");
      end
   endgenerate

   ctrl_t ctrl;

   instr_dec_ctrl u_ctrl (
      .op_i   (instr_i[15:12]),
      .ctrl_o (ctrl)
   );

   instr_dec_fields #(
      .XLEN    (XLEN),
      .SP_IDX  (SP_IDX),
      .WORD_SH (WORD_SH)
   ) u_fields (
      .instr_i     (instr_i),
      .ctrl_i      (ctrl),
      .dst_idx_o   (dst_idx_o),
      .src_a_idx_o (src_a_idx_o),
      .src_b_idx_o (src_b_idx_o),
      .data_idx_o  (data_idx_o),
      .imm_o       (imm_o),
      .cond_o      (cond_o)
   );

   instr_dec_guard #(
      .NUM_CONST (NUM_CONST),
      .PROTECT   (PROTECT)
   ) u_guard (
      .dst_idx_i (dst_idx_o),
      .we_raw_i  (ctrl.we),
      .we_o      (dst_we_o)
   );

   assign op_o       = instr_i[15:12];
   assign byte_wr_o  = ctrl.byte_wr;
   assign wb_sel_o   = ctrl.wb;
   assign sp_we_o    = ctrl.sp_up | ctrl.sp_dn;
   assign sp_delta_o = ctrl.sp_up ? STEP : (ctrl.sp_dn ? ('0 - STEP) : '0);
   assign mem_rd_o   = ctrl.mem_rd;
   assign mem_wr_o   = ctrl.mem_wr;
   assign mem_byte_o = ctrl.mem_byte;
   assign branch_o   = ctrl.branch;
   assign pc_we_o    = ctrl.pc_we;
   assign alu_o      = ctrl.alu;
   assign halt_o     = ctrl.halt;
   assign len_o      = ctrl.len;

endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
   parameter int NUM_CONST = 2,
   parameter bit PROTECT   = 1'b1,
   parameter int SP_IDX    = 14
) (
   input logic [15:0] instr_i,
   input logic [3:0]  dst_idx_o,
   input logic [3:0]  src_a_idx_o,
   input logic        dst_we_o,
   input logic        byte_wr_o,
   input logic [2:0]  wb_sel_o,
   input logic        sp_we_o,
   input logic        mem_rd_o,
   input logic        mem_wr_o,
   input logic        mem_byte_o,
   input logic        pc_we_o,
   input logic        alu_o,
   input logic        halt_o,
   input logic [2:0]  len_o
);

   logic [3:0] op;
   assign op = instr_i[15:12];

   always_comb begin
      if (!$isunknown(instr_i)) begin
         assert_len_R2: assert ((len_o == 3'd6) == (op == 4'd10) &&
                                (len_o == 3'd4) == (op == 4'd13))
            else $error("length does not match opcode");
         assert_const_we_R9: assert (!(PROTECT && dst_we_o &&
                                       (int'(dst_idx_o) < NUM_CONST)))
            else $error("write enable on constant register");
         assert_mem_excl_R5: assert (!(mem_rd_o && mem_wr_o))
            else $error("read and write in one access");
         assert_byte_mem_R5: assert (!mem_byte_o || mem_rd_o || mem_wr_o)
            else $error("byte flag without access");
         assert_halt_quiet_R10: assert (!halt_o ||
               !(dst_we_o || mem_rd_o || mem_wr_o || sp_we_o || pc_we_o))
            else $error("halt raises a write");
         assert_rsv_quiet_R11: assert (op < 4'd14 ||
               !(dst_we_o || mem_rd_o || mem_wr_o || sp_we_o || pc_we_o ||
                 halt_o || alu_o))
            else $error("reserved opcode active");
         assert_sp_src_R6: assert (!sp_we_o || int'(src_a_idx_o) == SP_IDX)
            else $error("stack step without stack pointer source");
         assert_byte_wr_R3: assert (!byte_wr_o || wb_sel_o == 3'd2 ||
                                    wb_sel_o == 3'd3)
            else $error("byte write from wrong source");
         assert_alu_only_R12: assert (alu_o == (op == 4'd3))
            else $error("alu flag on wrong opcode");
      end
   end

endmodule

bind instr_decoder instr_decoder_chk #(
   .NUM_CONST (NUM_CONST),
   .PROTECT   (PROTECT),
   .SP_IDX    (SP_IDX)
) u_chk (
   .instr_i     (instr_i),
   .dst_idx_o   (dst_idx_o),
   .src_a_idx_o (src_a_idx_o),
   .dst_we_o    (dst_we_o),
   .byte_wr_o   (byte_wr_o),
   .wb_sel_o    (wb_sel_o),
   .sp_we_o     (sp_we_o),
   .mem_rd_o    (mem_rd_o),
   .mem_wr_o    (mem_wr_o),
   .mem_byte_o  (mem_byte_o),
   .pc_we_o     (pc_we_o),
   .alu_o       (alu_o),
   .halt_o      (halt_o),
   .len_o       (len_o)
);

// File: tb/test_instr_decoder.sv
module test_instr_decoder;

   localparam int XLEN = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [15:0]     instr;
   logic [3:0]      op, dst, sa, sb, dat, cond;
   logic            we, bw, spwe, rd, wr, by, br, pcwe, alu, halt;
   logic [2:0]      wb, len;
   logic [XLEN-1:0] del, imm;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   instr_decoder i_instr_decoder (
      .instr_i (instr), .op_o (op), .dst_idx_o (dst), .src_a_idx_o (sa),
      .src_b_idx_o (sb), .data_idx_o (dat), .dst_we_o (we), .byte_wr_o (bw),
      .wb_sel_o (wb), .sp_we_o (spwe), .sp_delta_o (del), .mem_rd_o (rd),
      .mem_wr_o (wr), .mem_byte_o (by), .imm_o (imm), .cond_o (cond),
      .branch_o (br), .pc_we_o (pcwe), .alu_o (alu), .halt_o (halt),
      .len_o (len)
   );

   task automatic check(input string req, input logic [127:0] act,
                        input logic [127:0] exp, input logic [15:0] w);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s instr=%h actual=%h expected=%h", req, w, act, exp);
      end
   endtask

   task automatic run_one(input logic [15:0] w);
      logic [3:0] eo, r2, r1, r0, edst, ea, eb, edat, econd;
      logic ewe, ebw, espwe, erd, ewr, eby, ebr, epc, ealu, ehalt;
      logic [2:0] ewb, elen;
      logic [XLEN-1:0] edel, eimm;
      string tag;
      @(posedge clk);
      instr = w;
      eo = w[15:12]; r2 = w[11:8]; r1 = w[7:4]; r0 = w[3:0];
      edst = 0; ea = 0; eb = 0; edat = 0; econd = 0;
      ewe = 0; ebw = 0; espwe = 0; erd = 0; ewr = 0; eby = 0;
      ebr = 0; epc = 0; ealu = 0; ehalt = 0; ewb = 0; elen = 2;
      edel = 0; eimm = 0; tag = "R11";
      case (eo)
         4'd0:  begin tag = "R1"; edst = r2; ewe = 1; ea = r1; eb = r0; end
         4'd1:  begin tag = "R6"; edst = r2; ewe = 1; ewb = 2; ea = 14;
                      erd = 1; espwe = 1; edel = 4; end
         4'd2:  begin tag = "R6"; ea = 14; edat = r2; ewr = 1; espwe = 1;
                      edel = -4; end
         4'd3:  begin tag = "R12"; edst = r2; ewe = 1; ewb = 1; ea = r1;
                      eb = r0; ealu = 1; end
         4'd4:  begin tag = "R4"; edst = r2; ewe = 1; ea = r1;
                      eimm = 4 * $signed({{28{r0[3]}}, r0}); end
         4'd5, 4'd6: begin tag = "R5"; ea = r1; eb = r0; edat = r2; ewr = 1;
                      eby = (eo == 5); end
         4'd7, 4'd8: begin tag = "R5"; edst = r2; ewe = 1; ewb = 2; ea = r1;
                      eb = r0; erd = 1; eby = (eo == 7); ebw = (eo == 7); end
         4'd9:  begin tag = "R3"; edst = r2; ewe = 1; ewb = 3; ebw = 1;
                      eimm = {24'd0, r1, r0}; end
         4'd10: begin tag = "R13"; edst = r2; ewe = 1; ewb = 4; elen = 6; end
         4'd11: begin tag = "R7"; edst = r2; ewe = 1; ewb = 5; ea = r1;
                      eb = r0; epc = 1; end
         4'd12: begin tag = "R10"; ehalt = 1; end
         4'd13: begin tag = "R8"; edst = r1; ewe = 1; ewb = 6; econd = r2;
                      ebr = 1; elen = 4; end
         default: ;
      endcase
      if (ewe && edst < 2) begin tag = "R9"; ewe = 0; end
      @(negedge clk);
      check(tag,
            {27'd0, op, dst, sa, sb, dat, we, bw, wb, spwe, del, rd, wr, by,
             imm, cond, br, pcwe, alu, halt},
            {27'd0, eo, edst, ea, eb, edat, ewe, ebw, ewb, espwe, edel, erd,
             ewr, eby, eimm, econd, ebr, epc, ealu, ehalt}, w);
      check("R2", {125'd0, len}, {125'd0, elen}, w);
   endtask

   initial begin
      instr = 16'h0000;
      repeat (3) @(posedge clk);
      // R9: move r0,r0,r0 out of reset must not write the constant register
      @(negedge clk);
      check("R9", {127'd0, we}, 128'd0, instr);
      rst_n = 1'b1;
      // R4 corner: mover r5,r6,-8 gives -32
      run_one(16'h4568);
      check("R4", {96'd0, imm}, {96'd0, 32'hFFFF_FFE0}, 16'h4568);
      // R3 corner: loadi r2,#FF stays zero-extended
      run_one(16'h92FF);
      check("R3", {96'd0, imm}, {96'd0, 32'h0000_00FF}, 16'h92FF);
      for (int i = 0; i < 65536; i++) run_one(16'(i));
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule